// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a 16-bit fixed-point signal processor. Each accepted operation takes two 16-bit operands and, where it needs one, a third operand from one of four 36-bit accumulators. It writes one 36-bit result back into a chosen accumulator. Each accumulator holds a 32-bit value with four guard bits above it, so long runs of accumulation can grow past 32 bits without wrapping.

Multiplies can be integer or fractional. In fractional mode the product is doubled to remove the duplicate sign bit and is clamped to the signed 32-bit range. Each operand can be signed or unsigned. An unsigned-by-unsigned multiply is legal only in integer mode, and a fractional request for it is refused. The unit also adds and subtracts between accumulators and applies bitwise logic to the upper word of an accumulator. A separate read port gives any accumulator as a 16-bit upper word or as a 32-bit value. Both are clamped when the guard bits carry significant data.

Top module: `fxp_mac_unit`

## Requirements
- R1: During and directly after reset, all four accumulators read as zero and `res`, `ovf`, `res_vld` and `reject` are 0.
- R2: An accepted operation (in_valid=1 and not refused) writes accumulator `dst_sel` at the next rising edge. In the same cycle `res` shows the new value and `res_vld` is 1. A cycle without in_valid changes no accumulator, drives `res_vld` and `reject` to 0, and holds `res` and `ovf`.
- R3: Integer multiply (`frac`=0), opcode 0 (load): the accumulator receives the exact product extended to 36 bits. `sgn_mode` 00 treats both operands as signed. 01 treats x as signed and y as unsigned. 10 and 11 treat both as unsigned, and the product is zero-extended.
- R4: Fractional multiply (`frac`=1): the product is twice the integer product, clamped to [0x80000000, 0x7FFFFFFF] and sign-extended. For example, 0x8000 × 0x8000 gives 0x007FFFFFFF.
- R5: A request with `frac`=1 and `sgn_mode`[1]=1 is refused. `reject` is 1 in the next cycle with `res_vld`=0, no accumulator changes, and `res` and `ovf` hold.
- R6: Opcode 1 adds the extended product to accumulator `dst_sel`, and opcode 2 subtracts it. Both wrap modulo 2^36.
- R7: Opcode 3 sets dst = dst + acc[`src_sel`], and opcode 4 sets dst = dst − acc[`src_sel`]. Both wrap modulo 2^36.
- R8: Opcodes 5, 6 and 7 apply AND, OR and XOR of `x_op` to bits 31:16 of the destination. Bits 35:32 and 15:0 are unchanged.
- R9: `ovf` is 1 exactly when bits 35:32 of `res` are not all equal to bit 31 of `res`.
- R10: `rd_hi16` shows bits 31:16 of acc[`rd_sel`] when that value fits in signed 32 bits. Otherwise it shows 0x7FFF for a positive value and 0x8000 for a negative value.
- R11: `rd_w32` shows bits 31:0 of acc[`rd_sel`] when that value fits in signed 32 bits. Otherwise it shows 0x7FFFFFFF for a positive value and 0x80000000 for a negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 3 | Operation code (0 load, 1 mac, 2 msub, 3 add, 4 sub, 5 and, 6 or, 7 xor) |
| frac | input | 1 | 1 selects the fractional multiply format |
| sgn_mode | input | 2 | Operand signedness: 00 ss, 01 su, 1x uu |
| x_op | input | 16 | First multiplier operand; logic operand |
| y_op | input | 16 | Second multiplier operand |
| dst_sel | input | 2 | Destination accumulator |
| src_sel | input | 2 | Source accumulator for add and sub |
| rd_sel | input | 2 | Accumulator shown on the read port |
| res | output | 36 | Last written result |
| ovf | output | 1 | Last result exceeds the signed 32-bit range |
| res_vld | output | 1 | `res` was updated this cycle |
| reject | output | 1 | The previous request was refused |
| rd_hi16 | output | 16 | Clamped upper word of the selected accumulator |
| rd_w32 | output | 32 | Clamped 32-bit value of the selected accumulator |

## Verification
A wrong accumulator value, whether from bad product extension, a dropped guard bit or a write to the wrong register, shows up at once on the read port once `rd_sel` points at that register. It also shows up in `res` the next time that register is a destination or a source. The bench keeps its own copy of all four accumulators and walks `rd_sel` across them, so a corruption is caught within a few cycles. A mistaken overflow or clamping rule shows up in the same cycle as the result that triggers it, because `ovf`, `rd_hi16` and `rd_w32` are compared on every clock.

// File: rtl/fxp_mac_pkg.sv
// Shared widths and the operation code for the multiply-accumulate unit.
// Assumes operands of 16 bits and a 36-bit accumulator with 4 guard bits.
package fxp_mac_pkg;
    localparam int unsigned OPND_W  = 16;
    localparam int unsigned GUARD_W = 4;
    localparam int unsigned NUM_ACC = 4;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_MAC  = 3'd1,
        OP_MSUB = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_XOR  = 3'd7
    } mac_op_e;
endpackage

// File: rtl/fxp_mul.sv
// Operand multiplier: extends each operand by its signedness, multiplies,
// and in fractional mode doubles and clamps to signed 32 bits.
// Assumes GUARD_W >= 2 so the exact integer product fits the accumulator.
module fxp_mul #(
    parameter int unsigned OPND_W  = 16,
    parameter int unsigned GUARD_W = 4,
    localparam int unsigned PROD_W = 2 * OPND_W,
    localparam int unsigned ACC_W  = PROD_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPND_W-1:0] x_op,
    input  logic [OPND_W-1:0] y_op,
    input  logic              frac,
    input  logic [1:0]        sgn_mode,
    output logic [ACC_W-1:0]  prod_ext,
    output logic              illegal
);
    localparam int unsigned EXT_W = OPND_W + 1;
    localparam int unsigned MUL_W = 2 * EXT_W;

    logic                    x_signed;
    logic                    y_signed;
    logic signed [MUL_W-1:0] x_wide;
    logic signed [MUL_W-1:0] y_wide;
    logic signed [MUL_W-1:0] raw;
    logic        [MUL_W:0]   dbl;
    logic                    dbl_fits;
    logic        [PROD_W-1:0] frac_p;

    // Widen both operands according to the signedness mode.
    always_comb begin
        x_signed = ~sgn_mode[1];
        y_signed = (sgn_mode == 2'b00);
        x_wide   = {{(MUL_W-OPND_W){x_signed & x_op[OPND_W-1]}}, x_op};
        y_wide   = {{(MUL_W-OPND_W){y_signed & y_op[OPND_W-1]}}, y_op};
        raw      = x_wide * y_wide;
    end

    // Fractional scaling: double the product and clamp to signed 32 bits.
    always_comb begin
        dbl      = {raw, 1'b0};
        dbl_fits = (&dbl[MUL_W:PROD_W-1]) | ~(|dbl[MUL_W:PROD_W-1]);
        if (dbl_fits)
            frac_p = dbl[PROD_W-1:0];
        else if (dbl[MUL_W])
            frac_p = {1'b1, {(PROD_W-1){1'b0}}};
        else
            frac_p = {1'b0, {(PROD_W-1){1'b1}}};
    end

    // Choose the format and flag the unsupported fractional unsigned case.
    always_comb begin
        illegal = frac & sgn_mode[1];
        if (frac)
            prod_ext = {{(ACC_W-PROD_W){frac_p[PROD_W-1]}}, frac_p};
        else
            prod_ext = {{(ACC_W-MUL_W){raw[MUL_W-1]}}, raw};
    end

    assert_frac_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frac && !illegal) |->
        ((&prod_ext[ACC_W-1:PROD_W-1]) || !(|prod_ext[ACC_W-1:PROD_W-1])));

    assert_unsigned_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frac && sgn_mode[1]) |-> !prod_ext[ACC_W-1]);
endmodule

// File: rtl/fxp_alu.sv
// Accumulator arithmetic and logic: load, add or subtract the product,
// add or subtract another accumulator, and bitwise logic on the upper word.
// Arithmetic wraps at the accumulator width; overflow flags a guard mismatch.
module fxp_alu
    import fxp_mac_pkg::*;
#(
    parameter int unsigned OPND_W  = 16,
    parameter int unsigned GUARD_W = 4,
    localparam int unsigned PROD_W = 2 * OPND_W,
    localparam int unsigned ACC_W  = PROD_W + GUARD_W
) (
    input  mac_op_e           op,
    input  logic [ACC_W-1:0]  dst_val,
    input  logic [ACC_W-1:0]  src_val,
    input  logic [ACC_W-1:0]  prod,
    input  logic [OPND_W-1:0] x_op,
    output logic [ACC_W-1:0]  result,
    output logic              ovf
);
    // Compute the new destination value for the selected operation.
    always_comb begin
        result = dst_val;
        unique case (op)
            OP_LOAD: result = prod;
            OP_MAC:  result = dst_val + prod;
            OP_MSUB: result = dst_val - prod;
            OP_ADD:  result = dst_val + src_val;
            OP_SUB:  result = dst_val - src_val;
            OP_AND:  result[PROD_W-1:OPND_W] = dst_val[PROD_W-1:OPND_W] & x_op;
            OP_OR:   result[PROD_W-1:OPND_W] = dst_val[PROD_W-1:OPND_W] | x_op;
            OP_XOR:  result[PROD_W-1:OPND_W] = dst_val[PROD_W-1:OPND_W] ^ x_op;
            default: result = dst_val;
        endcase
    end

    // Flag a result whose guard bits are not a sign extension of bit 31.
    always_comb begin
        ovf = ~((&result[ACC_W-1:PROD_W-1]) | ~(|result[ACC_W-1:PROD_W-1]));
    end
endmodule

// File: rtl/fxp_acc_bank.sv
// Register file of accumulators with one write port and three read ports.
// Assumes at most one write per cycle; reset clears every register.
module fxp_acc_bank #(
    parameter int unsigned ACC_W   = 36,
    parameter int unsigned NUM_ACC = 4,
    localparam int unsigned SEL_W  = $clog2(NUM_ACC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [ACC_W-1:0] wdata,
    input  logic [SEL_W-1:0] dsel,
    input  logic [SEL_W-1:0] ssel,
    input  logic [SEL_W-1:0] rsel,
    output logic [ACC_W-1:0] dst_q,
    output logic [ACC_W-1:0] src_q,
    output logic [ACC_W-1:0] rd_q
);
    logic [ACC_W-1:0] acc_q [NUM_ACC];

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        // Hold or overwrite one accumulator.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[g] <= '0;
            else if (we && (wsel == SEL_W'(g)))
                acc_q[g] <= wdata;
        end

        assert_hold_when_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (wsel == SEL_W'(g))) |=> $stable(acc_q[g]));

        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (wsel == SEL_W'(g))) |=> (acc_q[g] == $past(wdata)));
    end

    // Read ports for the destination, the source and the readout.
    assign dst_q = acc_q[dsel];
    assign src_q = acc_q[ssel];
    assign rd_q  = acc_q[rsel];
endmodule

// File: rtl/fxp_sat_read.sv
// Clamped readout of the top OUT_W bits of the 32-bit value in an accumulator.
// Assumes OUT_W <= VAL_W; a value outside signed VAL_W bits reads as the extreme.
module fxp_sat_read #(
    parameter int unsigned ACC_W = 36,
    parameter int unsigned VAL_W = 32,
    parameter int unsigned OUT_W = 16
) (
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] dout
);
    logic fits;

    // Pass the word through or substitute the clamp value of the sign.
    always_comb begin
        fits = (&acc[ACC_W-1:VAL_W-1]) | ~(|acc[ACC_W-1:VAL_W-1]);
        if (fits)
            dout = acc[VAL_W-1 -: OUT_W];
        else if (acc[ACC_W-1])
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        else
            dout = {1'b0, {(OUT_W-1){1'b1}}};
    end
endmodule

// File: rtl/fxp_mac_unit.sv
// Top of the fixed-point multiply-accumulate unit. Registers each accepted
// result one cycle after in_valid, refuses fractional unsigned-by-unsigned
// requests, and offers clamped 16- and 32-bit readouts of any accumulator.
module fxp_mac_unit
    import fxp_mac_pkg::*;
#(
    parameter int unsigned OP_W   = fxp_mac_pkg::OPND_W,
    parameter int unsigned G_W    = fxp_mac_pkg::GUARD_W,
    parameter int unsigned N_ACC  = fxp_mac_pkg::NUM_ACC,
    localparam int unsigned P_W   = 2 * OP_W,
    localparam int unsigned A_W   = P_W + G_W,
    localparam int unsigned S_W   = $clog2(N_ACC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     opcode,
    input  logic           frac,
    input  logic [1:0]     sgn_mode,
    input  logic [OP_W-1:0] x_op,
    input  logic [OP_W-1:0] y_op,
    input  logic [S_W-1:0] dst_sel,
    input  logic [S_W-1:0] src_sel,
    input  logic [S_W-1:0] rd_sel,
    output logic [A_W-1:0] res,
    output logic           ovf,
    output logic           res_vld,
    output logic           reject,
    output logic [OP_W-1:0] rd_hi16,
    output logic [P_W-1:0] rd_w32
);
    logic [A_W-1:0] prod_ext;
    logic           illegal;
    logic [A_W-1:0] dst_q;
    logic [A_W-1:0] src_q;
    logic [A_W-1:0] rd_q;
    logic [A_W-1:0] alu_res;
    logic           alu_ovf;
    logic           accept;

    assign accept = in_valid & ~illegal;

    fxp_mul #(.OPND_W(OP_W), .GUARD_W(G_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .x_op     (x_op),
        .y_op     (y_op),
        .frac     (frac),
        .sgn_mode (sgn_mode),
        .prod_ext (prod_ext),
        .illegal  (illegal)
    );

    fxp_acc_bank #(.ACC_W(A_W), .NUM_ACC(N_ACC)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept),
        .wsel  (dst_sel),
        .wdata (alu_res),
        .dsel  (dst_sel),
        .ssel  (src_sel),
        .rsel  (rd_sel),
        .dst_q (dst_q),
        .src_q (src_q),
        .rd_q  (rd_q)
    );

    fxp_alu #(.OPND_W(OP_W), .GUARD_W(G_W)) u_alu (
        .op      (mac_op_e'(opcode)),
        .dst_val (dst_q),
        .src_val (src_q),
        .prod    (prod_ext),
        .x_op    (x_op),
        .result  (alu_res),
        .ovf     (alu_ovf)
    );

    fxp_sat_read #(.ACC_W(A_W), .VAL_W(P_W), .OUT_W(OP_W)) u_rd_hi (
        .acc  (rd_q),
        .dout (rd_hi16)
    );

    fxp_sat_read #(.ACC_W(A_W), .VAL_W(P_W), .OUT_W(P_W)) u_rd_w (
        .acc  (rd_q),
        .dout (rd_w32)
    );

    // Register the result, its overflow flag and the handshake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res     <= '0;
            ovf     <= 1'b0;
            res_vld <= 1'b0;
            reject  <= 1'b0;
        end else begin
            res_vld <= accept;
            reject  <= in_valid & illegal;
            if (accept) begin
                res <= alu_res;
                ovf <= alu_ovf;
            end
        end
    end

    assert_one_cycle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (res_vld && !reject));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_vld && !reject && $stable(res) && $stable(ovf)));

    assert_frac_uu_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frac && sgn_mode[1]) |=> (reject && !res_vld && $stable(res)));

    assert_ovf_matches_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (ovf == !((&res[A_W-1:P_W-1]) || !(|res[A_W-1:P_W-1]))));

    assert_readouts_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi16 == rd_w32[P_W-1 -: OP_W]);
endmodule

// File: tb/tb_fxp_mac_unit.sv
// Self-checking bench: a behavioural model of the four accumulators is
// updated per operation and compared with every output after each clock.
module tb_fxp_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  opcode;
    logic        frac;
    logic [1:0]  sgn_mode;
    logic [15:0] x_op, y_op;
    logic [1:0]  dst_sel, src_sel, rd_sel;
    logic [35:0] res;
    logic        ovf, res_vld, reject;
    logic [15:0] rd_hi16;
    logic [31:0] rd_w32;

    int total = 0;
    int bad   = 0;

    logic [35:0] m_acc [4];
    logic [35:0] m_res;
    logic        m_ovf, m_vld, m_rej;

    always #10 clk = ~clk;

    fxp_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .frac(frac), .sgn_mode(sgn_mode), .x_op(x_op), .y_op(y_op),
        .dst_sel(dst_sel), .src_sel(src_sel), .rd_sel(rd_sel),
        .res(res), .ovf(ovf), .res_vld(res_vld), .reject(reject),
        .rd_hi16(rd_hi16), .rd_w32(rd_w32)
    );

    task automatic chk(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] m_prod(input logic [15:0] x, input logic [15:0] y,
                                           input logic f, input logic [1:0] md);
        longint xs, ys, p;
        xs = md[1] ? longint'(x) : longint'($signed(x));
        ys = (md == 2'b00) ? longint'($signed(y)) : longint'(y);
        p  = xs * ys;
        if (f) begin
            p = p * 2;
            if (p > 64'sd2147483647)  p = 64'sd2147483647;
            if (p < -64'sd2147483648) p = -64'sd2147483648;
        end
        return p[35:0];
    endfunction

    function automatic logic [31:0] m_sat32(input logic [35:0] a);
        longint v;
        v = longint'($signed(a));
        if (v > 64'sd2147483647)  return 32'h7FFFFFFF;
        if (v < -64'sd2147483648) return 32'h80000000;
        return a[31:0];
    endfunction

    task automatic compare_all(input string tag);
        logic [31:0] w;
        w = m_sat32(m_acc[rd_sel]);
        chk(tag,   "res",     res, m_res);
        chk("R9",  "ovf",     36'(ovf), 36'(m_ovf));
        chk("R2",  "res_vld", 36'(res_vld), 36'(m_vld));
        chk("R5",  "reject",  36'(reject), 36'(m_rej));
        chk("R10", "rd_hi16", 36'(rd_hi16), 36'(w[31:16]));
        chk("R11", "rd_w32",  36'(rd_w32), 36'(w));
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic f,
                        input logic [1:0] md, input logic [15:0] x, input logic [15:0] y,
                        input logic [1:0] d, input logic [1:0] s, input logic [1:0] r,
                        input string tag);
        logic [35:0] nv;
        @(negedge clk);
        in_valid = v; opcode = op; frac = f; sgn_mode = md;
        x_op = x; y_op = y; dst_sel = d; src_sel = s; rd_sel = r;
        m_vld = 1'b0;
        m_rej = 1'b0;
        if (v) begin
            if (f && md[1]) begin
                m_rej = 1'b1;
            end else begin
                nv = m_acc[d];
                case (op)
                    3'd0: nv = m_prod(x, y, f, md);
                    3'd1: nv = m_acc[d] + m_prod(x, y, f, md);
                    3'd2: nv = m_acc[d] - m_prod(x, y, f, md);
                    3'd3: nv = m_acc[d] + m_acc[s];
                    3'd4: nv = m_acc[d] - m_acc[s];
                    3'd5: nv[31:16] = m_acc[d][31:16] & x;
                    3'd6: nv[31:16] = m_acc[d][31:16] | x;
                    default: nv[31:16] = m_acc[d][31:16] ^ x;
                endcase
                m_acc[d] = nv;
                m_res    = nv;
                m_ovf    = !((nv[35:32] == 4'hF && nv[31]) || (nv[35:32] == 4'h0 && !nv[31]));
                m_vld    = 1'b1;
            end
        end
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; opcode = '0; frac = 1'b0; sgn_mode = '0;
        x_op = '0; y_op = '0; dst_sel = '0; src_sel = '0; rd_sel = '0;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_res = '0; m_ovf = 1'b0; m_vld = 1'b0; m_rej = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every accumulator reads zero after reset
        for (int i = 0; i < 4; i++)
            step(1'b0, 3'd0, 1'b0, 2'b00, 16'h0, 16'h0, 2'd0, 2'd0, 2'(i), "R1");

        // R3: integer products in each signedness mode
        step(1'b1, 3'd0, 1'b0, 2'b00, 16'hFFFD, 16'h0005, 2'd0, 2'd0, 2'd0, "R3");
        step(1'b1, 3'd0, 1'b0, 2'b01, 16'hFFFE, 16'hFFFF, 2'd1, 2'd0, 2'd1, "R3");
        step(1'b1, 3'd0, 1'b0, 2'b10, 16'hFFFF, 16'hFFFF, 2'd2, 2'd0, 2'd2, "R3");
        step(1'b1, 3'd0, 1'b0, 2'b11, 16'h8000, 16'h0002, 2'd2, 2'd0, 2'd2, "R3");

        // R4: fractional doubling and clamping
        step(1'b1, 3'd0, 1'b1, 2'b00, 16'h4000, 16'h4000, 2'd3, 2'd0, 2'd3, "R4");
        step(1'b1, 3'd0, 1'b1, 2'b00, 16'h8000, 16'h8000, 2'd0, 2'd0, 2'd0, "R4");
        step(1'b1, 3'd0, 1'b1, 2'b01, 16'h8000, 16'hFFFF, 2'd1, 2'd0, 2'd1, "R4");

        // R5: fractional unsigned-by-unsigned refused, accumulator 0 untouched
        step(1'b1, 3'd0, 1'b1, 2'b10, 16'h1234, 16'h5678, 2'd0, 2'd0, 2'd0, "R5");
        step(1'b1, 3'd1, 1'b1, 2'b11, 16'h7FFF, 16'h7FFF, 2'd0, 2'd0, 2'd0, "R5");
        step(1'b0, 3'd0, 1'b0, 2'b00, 16'h0, 16'h0, 2'd0, 2'd0, 2'd0, "R5");

        // R6: accumulate past 32 bits, then subtract below the negative limit
        step(1'b1, 3'd0, 1'b1, 2'b00, 16'h7FFF, 16'h7FFF, 2'd2, 2'd0, 2'd2, "R6");
        for (int i = 0; i < 4; i++)
            step(1'b1, 3'd1, 1'b1, 2'b00, 16'h7FFF, 16'h7FFF, 2'd2, 2'd0, 2'd2, "R6");
        for (int i = 0; i < 10; i++)
            step(1'b1, 3'd2, 1'b1, 2'b00, 16'h7FFF, 16'h7FFF, 2'd2, 2'd0, 2'd2, "R6");
        step(1'b1, 3'd1, 1'b0, 2'b00, 16'h0003, 16'hFFFF, 2'd1, 2'd0, 2'd1, "R6");

        // R7: accumulator add and subtract
        step(1'b1, 3'd3, 1'b0, 2'b00, 16'h0, 16'h0, 2'd3, 2'd0, 2'd3, "R7");
        step(1'b1, 3'd3, 1'b0, 2'b00, 16'h0, 16'h0, 2'd3, 2'd3, 2'd3, "R7");
        step(1'b1, 3'd4, 1'b0, 2'b00, 16'h0, 16'h0, 2'd0, 2'd2, 2'd0, "R7");

        // R8: logic on the upper word only
        step(1'b1, 3'd0, 1'b0, 2'b00, 16'h1234, 16'h5678, 2'd3, 2'd0, 2'd3, "R3");
        step(1'b1, 3'd5, 1'b0, 2'b00, 16'h0FF0, 16'h0, 2'd3, 2'd0, 2'd3, "R8");
        step(1'b1, 3'd6, 1'b0, 2'b00, 16'hF000, 16'h0, 2'd3, 2'd0, 2'd3, "R8");
        step(1'b1, 3'd7, 1'b0, 2'b00, 16'hFFFF, 16'h0, 2'd3, 2'd0, 2'd3, "R8");
        step(1'b1, 3'd7, 1'b0, 2'b00, 16'hA5A5, 16'h0, 2'd2, 2'd0, 2'd2, "R8");

        // R2 and R9: mixed traffic with idle gaps and all readouts
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            string tg;
            op = 3'($urandom);
            tg = (op == 3'd0) ? "R3" : (op <= 3'd2) ? "R6" : (op <= 3'd4) ? "R7" : "R8";
            step(($urandom % 5) != 0, op, 1'($urandom), 2'($urandom),
                 16'($urandom), 16'($urandom), 2'($urandom), 2'($urandom),
                 2'($urandom), tg);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule